// File: doc/BRIEF.md
# Bus Transaction Trace Buffer

This debug block records transactions from one of three internal transaction buses into an on-chip store of 256 entries, each 64 bits wide. A 3-bit source code in the control register picks the bus. Each captured transaction is packed into a fixed 64-bit record that holds its type, source ID, target ID, byte count and address.

A trigger mode decides which valid cycles are written. It can write every valid cycle, only cycles that coincide with a pulse from an external watchpoint comparator, or only cycles where every enabled condition in the condition register matches. The same condition logic also drives an event output whether or not capture is armed, so the unit can serve as a second watchpoint monitor.

A stop policy ends capture in one of two ways. With stop-on-event, the pointer wraps around the store and capture ends on a chosen event. With stop-when-full, capture ends once the last slot has been written. Software reads the records back through an index register and two 32-bit data windows.

Top module: `trace_capture_unit`

## Requirements
- R1: After reset the control, condition and status registers read zero and `match_evt_o` is low.
- R2: Control bits [6:4] select the source. Code 0 selects bus 0 (coherency dispatch), code 1 selects bus 1 (host-to-PCI) and code 2 selects bus 2 (host-to-DDR). Codes 3 to 7 capture nothing.
- R3: A record's upper word (bits 63:32) holds type[63:59], source ID[58:54], target ID[53:50] and byte count[49:45], with zeros in bits 44:32. Its lower word holds the 32-bit address.
- R4: Mode 0 (control bits [2:1] = 0) writes one record for every valid cycle of the selected bus while capture is active (enabled and not stopped). At most one record is written per clock.
- R5: Mode 1 writes a record only when the selected bus is valid in the same cycle as `wp_evt_i`.
- R6: Mode 2 writes a record only when the selected bus is valid and every enabled condition matches. The condition register holds the type value in [4:0] with its enable at [5], the source ID in [10:6] with its enable at [11], and the target ID in [15:12] with its enable at [16].
- R7: With control bit 3 set (stop-when-full), capture halts after slot 255 is written. The status register then shows write pointer 0 with full (bit 10) and stopped (bit 9) set, and later valid cycles change nothing.
- R8: With control bit 3 clear (stop-on-event), the write pointer wraps modulo 256 and sets the wrapped flag (status bit 8). The stop event halts capture after any record written in the event cycle. The status register shows the pointer in bits [7:0].
- R9: Control bit 7 chooses the stop event. A value of 0 selects the `wp_evt_i` pulse. A value of 1 selects a condition match on the selected bus.
- R10: Writing control bit 0 from 0 to 1 re-arms capture and clears the write pointer, wrapped, stopped and full.
- R11: The data windows (address 4 for the upper word, address 5 for the lower word) return the record at the index register (address 3). They return zero while capture is active.
- R12: `match_evt_o` goes high one cycle after the selected bus is valid with all enabled conditions matching. This holds whether or not capture is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld_i | input | 3 | Valid strobe per observed bus |
| bus_tt_i | input | 3x5 | Transaction type per bus |
| bus_sid_i | input | 3x5 | Source ID per bus |
| bus_tid_i | input | 3x4 | Target ID per bus |
| bus_bc_i | input | 3x5 | Byte count per bus |
| bus_addr_i | input | 3x32 | Transaction address per bus |
| wp_evt_i | input | 1 | Pulse from external watchpoint comparator |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 ctrl, 1 cond, 2 status, 3 index, 4 data hi, 5 data lo) |
| reg_wdata_i | input | 17 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| match_evt_o | output | 1 | Condition-match event output |

## Verification
The assertions check several rules on every cycle. The write pointer never moves once capture has stopped, unless the unit is re-armed. Full never appears without stopped. Codes 3 to 7 never produce a write. The data windows stay at zero while capture is active. A re-arm always clears the pointer and flags. The match event always follows a qualifying cycle. Only the bench scenarios can show the record bit layout, which cycles each trigger mode picks, the exact slot where capture stops after a fill or after a wrapped run with an event, and which stop source is honoured.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int TT_W  = 5;
    localparam int SID_W = 5;
    localparam int TID_W = 4;
    localparam int BC_W  = 5;
    localparam int AD_W  = 32;
    localparam int ENT_W = 64;
    localparam int HDR_W = TT_W + SID_W + TID_W + BC_W;
    localparam int PAD_W = ENT_W / 2 - HDR_W;

    typedef enum logic [1:0] {
        TRIG_ALL  = 2'd0,
        TRIG_WP   = 2'd1,
        TRIG_COND = 2'd2,
        TRIG_OFF  = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic       stop_on_cond;
        logic [2:0] src_sel;
        logic       halt_full;
        trig_mode_e mode;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic             tid_en;
        logic [TID_W-1:0] tid;
        logic             sid_en;
        logic [SID_W-1:0] sid;
        logic             tt_en;
        logic [TT_W-1:0]  tt;
    } cond_t;

    typedef struct packed {
        logic [TT_W-1:0]  tt;
        logic [SID_W-1:0] sid;
        logic [TID_W-1:0] tid;
        logic [BC_W-1:0]  bc;
        logic [AD_W-1:0]  addr;
    } txn_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int COND_W = $bits(cond_t);

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_COND  = 3'd1;
    localparam logic [2:0] RA_STAT  = 3'd2;
    localparam logic [2:0] RA_INDEX = 3'd3;
    localparam logic [2:0] RA_DHI   = 3'd4;
    localparam logic [2:0] RA_DLO   = 3'd5;
endpackage

// File: rtl/trc_src_sel.sv
module trc_src_sel
    import trc_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] vld_i,
    input  txn_t               txn_i [NUM_SRC],
    input  logic [SEL_W-1:0]   sel_i,
    output logic               vld_o,
    output txn_t               txn_o
);
    always_comb begin
        vld_o = 1'b0;
        txn_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) begin
                vld_o = vld_i[i];
                txn_o = txn_i[i];
            end
        end
    end
endmodule

// File: rtl/trc_cond.sv
module trc_cond
    import trc_pkg::*;
(
    input  logic [TT_W-1:0]  tt_i,
    input  logic [SID_W-1:0] sid_i,
    input  logic [TID_W-1:0] tid_i,
    input  cond_t            cond_i,
    output logic             ok_o
);
    logic tt_ok, sid_ok, tid_ok;

    always_comb begin
        tt_ok  = !cond_i.tt_en  || (tt_i  == cond_i.tt);
        sid_ok = !cond_i.sid_en || (sid_i == cond_i.sid);
        tid_ok = !cond_i.tid_en || (tid_i == cond_i.tid);
        ok_o   = tt_ok && sid_ok && tid_ok;
    end
endmodule

// File: rtl/trc_store.sv
module trc_store #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/trace_capture_unit.sv
module trace_capture_unit
    import trc_pkg::*;
#(
    parameter int NUM_SRC  = 3,
    parameter int DEPTH    = 256,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int WD_W    = COND_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            bus_vld_i,
    input  logic [NUM_SRC-1:0][TT_W-1:0]  bus_tt_i,
    input  logic [NUM_SRC-1:0][SID_W-1:0] bus_sid_i,
    input  logic [NUM_SRC-1:0][TID_W-1:0] bus_tid_i,
    input  logic [NUM_SRC-1:0][BC_W-1:0]  bus_bc_i,
    input  logic [NUM_SRC-1:0][AD_W-1:0]  bus_addr_i,
    input  logic                          wp_evt_i,
    input  logic                          reg_wr_i,
    input  logic [2:0]                    reg_addr_i,
    input  logic [WD_W-1:0]               reg_wdata_i,
    output logic [31:0]                   reg_rdata_o,
    output logic                          match_evt_o
);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    typedef struct packed {
        ctrl_t            ctrl;
        cond_t            cond;
        logic [PTR_W-1:0] idx;
        logic [PTR_W-1:0] wptr;
        logic             wrapped;
        logic             stopped;
        logic             full;
        logic             mevt;
    } state_t;

    state_t st_d, st_q;

    txn_t             txn_arr [NUM_SRC];
    logic             sel_vld;
    txn_t             sel_txn;
    logic             cond_ok;
    logic             cond_hit;
    logic             active;
    logic             trig;
    logic             wr_en;
    logic             arm;
    logic             stop_evt;
    logic [ENT_W-1:0] wr_rec;
    logic [ENT_W-1:0] rd_rec;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign txn_arr[g] = '{tt:   bus_tt_i[g],
                              sid:  bus_sid_i[g],
                              tid:  bus_tid_i[g],
                              bc:   bus_bc_i[g],
                              addr: bus_addr_i[g]};
    end

    trc_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(3)) src_sel_i (
        .vld_i (bus_vld_i),
        .txn_i (txn_arr),
        .sel_i (st_q.ctrl.src_sel),
        .vld_o (sel_vld),
        .txn_o (sel_txn)
    );

    trc_cond cond_i (
        .tt_i   (sel_txn.tt),
        .sid_i  (sel_txn.sid),
        .tid_i  (sel_txn.tid),
        .cond_i (st_q.cond),
        .ok_o   (cond_ok)
    );

    assign wr_rec = {sel_txn.tt, sel_txn.sid, sel_txn.tid, sel_txn.bc,
                     {PAD_W{1'b0}}, sel_txn.addr};

    trc_store #(.DEPTH(DEPTH), .WIDTH(ENT_W)) store_i (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (st_q.wptr),
        .wdata_i (wr_rec),
        .raddr_i (st_q.idx),
        .rdata_o (rd_rec)
    );

    always_comb begin
        st_d     = st_q;
        cond_hit = sel_vld && cond_ok;
        active   = st_q.ctrl.en && !st_q.stopped;
        unique case (st_q.ctrl.mode)
            TRIG_ALL:  trig = sel_vld;
            TRIG_WP:   trig = sel_vld && wp_evt_i;
            TRIG_COND: trig = cond_hit;
            default:   trig = 1'b0;
        endcase
        wr_en    = active && trig;
        stop_evt = active && !st_q.ctrl.halt_full &&
                   (st_q.ctrl.stop_on_cond ? cond_hit : wp_evt_i);
        arm      = reg_wr_i && (reg_addr_i == RA_CTRL) &&
                   reg_wdata_i[0] && !st_q.ctrl.en;

        st_d.mevt = cond_hit;

        if (wr_en) begin
            st_d.wptr = st_q.wptr + 1'b1;
            if (st_q.wptr == LAST_SLOT) begin
                if (st_q.ctrl.halt_full) begin
                    st_d.full    = 1'b1;
                    st_d.stopped = 1'b1;
                end else begin
                    st_d.wrapped = 1'b1;
                end
            end
        end
        if (stop_evt) begin
            st_d.stopped = 1'b1;
        end

        if (reg_wr_i) begin
            unique case (reg_addr_i)
                RA_CTRL:  st_d.ctrl = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
                RA_COND:  st_d.cond = cond_t'(reg_wdata_i);
                RA_INDEX: st_d.idx  = reg_wdata_i[PTR_W-1:0];
                default:  ;
            endcase
        end
        if (arm) begin
            st_d.wptr    = '0;
            st_d.wrapped = 1'b0;
            st_d.stopped = 1'b0;
            st_d.full    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            RA_CTRL:  reg_rdata_o[CTRL_W-1:0] = st_q.ctrl;
            RA_COND:  reg_rdata_o[COND_W-1:0] = st_q.cond;
            RA_STAT: begin
                reg_rdata_o[PTR_W-1:0] = st_q.wptr;
                reg_rdata_o[PTR_W]     = st_q.wrapped;
                reg_rdata_o[PTR_W+1]   = st_q.stopped;
                reg_rdata_o[PTR_W+2]   = st_q.full;
            end
            RA_INDEX: reg_rdata_o[PTR_W-1:0] = st_q.idx;
            RA_DHI:   reg_rdata_o = active ? 32'd0 : rd_rec[ENT_W-1:ENT_W/2];
            RA_DLO:   reg_rdata_o = active ? 32'd0 : rd_rec[ENT_W/2-1:0];
            default:  reg_rdata_o = '0;
        endcase
    end

    assign match_evt_o = st_q.mevt;
endmodule

// File: rtl/trace_capture_unit_chk.sv
module trace_capture_unit_chk
    import trc_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic             wdata_en,
    input logic [31:0]      rdata,
    input logic             en,
    input logic             stopped,
    input logic             full,
    input logic             wrapped,
    input logic [PTR_W-1:0] wptr,
    input logic             wr_en,
    input logic             sel_vld,
    input logic [2:0]       src_sel,
    input logic             cond_hit,
    input logic             mevt
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);

    // R4
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sel_vld);

    // R2
    bad_src_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel > 3'd2) |-> !wr_en);

    // R7
    full_means_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> stopped);

    // R8
    frozen_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !ctrl_wr) |=> (wptr == $past(wptr)));

    // R10
    rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata_en && !en) |=> (wptr == '0 && !stopped && !full && !wrapped));

    // R11
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !stopped && (reg_addr == RA_DHI || reg_addr == RA_DLO)) |-> (rdata == 32'd0));

    // R12
    match_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mevt |-> $past(cond_hit));
endmodule

bind trace_capture_unit trace_capture_unit_chk #(.PTR_W(PTR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr_i),
    .reg_addr (reg_addr_i),
    .wdata_en (reg_wdata_i[0]),
    .rdata    (reg_rdata_o),
    .en       (st_q.ctrl.en),
    .stopped  (st_q.stopped),
    .full     (st_q.full),
    .wrapped  (st_q.wrapped),
    .wptr     (st_q.wptr),
    .wr_en    (wr_en),
    .sel_vld  (sel_vld),
    .src_sel  (st_q.ctrl.src_sel),
    .cond_hit (cond_hit),
    .mevt     (match_evt_o)
);

// File: tb/trace_capture_unit_tb_top.sv
module trace_capture_unit_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        bvld = '0;
    logic [2:0][4:0]   btt = '0;
    logic [2:0][4:0]   bsid = '0;
    logic [2:0][3:0]   btid = '0;
    logic [2:0][4:0]   bbc = '0;
    logic [2:0][31:0]  baddr = '0;
    logic              wp = 1'b0;
    logic              rwr = 1'b0;
    logic [2:0]        raddr = '0;
    logic [16:0]       rwdata = '0;
    logic [31:0]       rdata;
    logic              mevt;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    trace_capture_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_vld_i(bvld), .bus_tt_i(btt), .bus_sid_i(bsid), .bus_tid_i(btid),
        .bus_bc_i(bbc), .bus_addr_i(baddr), .wp_evt_i(wp),
        .reg_wr_i(rwr), .reg_addr_i(raddr), .reg_wdata_i(rwdata),
        .reg_rdata_o(rdata), .match_evt_o(mevt)
    );

    // stimulus vector: {sel, tt, sid, tid, bc, addr}
    localparam int NV = 6;
    localparam logic [53:0] VEC [NV] = '{
        {3'd0, 5'h1F, 5'h15, 4'hA, 5'h11, 32'hDEADBEEF},
        {3'd1, 5'h00, 5'h01, 4'h1, 5'h01, 32'h00000004},
        {3'd2, 5'h0A, 5'h1E, 4'hF, 5'h1F, 32'h80000000},
        {3'd0, 5'h15, 5'h0A, 4'h5, 5'h0A, 32'h12345678},
        {3'd3, 5'h03, 5'h03, 4'h3, 5'h03, 32'h33333333},
        {3'd7, 5'h07, 5'h07, 4'h7, 5'h07, 32'h77777777}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [16:0] d);
        rwr = 1'b1; raddr = a; rwdata = d;
        @(negedge clk);
        rwr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        raddr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_entry(input int idx, output logic [31:0] hi, output logic [31:0] lo);
        wreg(3'd3, 17'(idx));
        rreg(3'd4, hi);
        rreg(3'd5, lo);
    endtask

    task automatic drive0(input logic [4:0] tt, input logic [3:0] tid,
                          input logic [31:0] ad, input logic w);
        bvld[0] = 1'b1; btt[0] = tt; bsid[0] = 5'h02; btid[0] = tid;
        bbc[0] = 5'h04; baddr[0] = ad; wp = w;
        @(negedge clk);
        bvld[0] = 1'b0; wp = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1..: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, hi, lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(3'd0, v); chk("R1 ctrl", v, 0);
        rreg(3'd1, v); chk("R1 cond", v, 0);
        rreg(3'd2, v); chk("R1 status", v, 0);
        chk("R1 match_evt", 32'(mevt), 0);

        // R2/R3/R4 table walk
        for (int k = 0; k < NV; k++) begin
            logic [2:0] s;
            logic valid_sel;
            s = VEC[k][53:51];
            valid_sel = (s <= 3'd2);
            wreg(3'd0, 17'({s, 4'b0000}));
            wreg(3'd0, 17'({s, 4'b0001}));
            for (int b = 0; b < 3; b++) begin
                bvld[b] = 1'b1;
                btt[b]   = (s == 3'(b)) ? VEC[k][50:46] : ~VEC[k][50:46];
                bsid[b]  = (s == 3'(b)) ? VEC[k][45:41] : ~VEC[k][45:41];
                btid[b]  = (s == 3'(b)) ? VEC[k][40:37] : ~VEC[k][40:37];
                bbc[b]   = (s == 3'(b)) ? VEC[k][36:32] : ~VEC[k][36:32];
                baddr[b] = (s == 3'(b)) ? VEC[k][31:0]  : ~VEC[k][31:0];
            end
            @(negedge clk);
            bvld = '0;
            wreg(3'd0, 17'({s, 4'b0000}));
            rreg(3'd2, v);
            chk($sformatf("R2 count sel=%0d", s), v, valid_sel ? 32'd1 : 32'd0);
            if (valid_sel) begin
                rd_entry(0, hi, lo);
                chk($sformatf("R3 hi sel=%0d", s), hi,
                    {VEC[k][50:46], VEC[k][45:41], VEC[k][40:37], VEC[k][36:32], 13'd0});
                chk($sformatf("R3 lo sel=%0d", s), lo, VEC[k][31:0]);
            end
        end

        // R11 read gating while active
        wreg(3'd0, 17'h00); wreg(3'd0, 17'h09);
        drive0(5'h1, 4'h1, 32'hCAFE0001, 1'b0);
        wreg(3'd3, 17'd0);
        rreg(3'd4, v); chk("R11 hi gated", v, 0);
        rreg(3'd5, v); chk("R11 lo gated", v, 0);
        wreg(3'd0, 17'h08);
        rreg(3'd5, v); chk("R11 lo after disable", v, 32'hCAFE0001);

        // R5 watchpoint mode
        wreg(3'd0, 17'h0B);
        drive0(5'h1, 4'h1, 32'd100, 1'b0);
        drive0(5'h1, 4'h1, 32'd101, 1'b1);
        drive0(5'h1, 4'h1, 32'd102, 1'b0);
        wreg(3'd0, 17'h08);
        rreg(3'd2, v); chk("R5 count", v, 1);
        rd_entry(0, hi, lo); chk("R5 entry", lo, 101);

        // R6 condition mode, R12 match event
        wreg(3'd1, 17'h12023);
        wreg(3'd0, 17'h0D);
        drive0(5'h3, 4'h1, 32'd200, 1'b0);
        chk("R12 no match", 32'(mevt), 0);
        drive0(5'h3, 4'h2, 32'd201, 1'b0);
        chk("R12 match", 32'(mevt), 1);
        drive0(5'h4, 4'h2, 32'd202, 1'b0);
        wreg(3'd0, 17'h00);
        rreg(3'd2, v); chk("R6 count", v, 1);
        rd_entry(0, hi, lo); chk("R6 entry", lo, 201);
        drive0(5'h3, 4'h2, 32'd203, 1'b0);
        chk("R12 match while disabled", 32'(mevt), 1);
        rreg(3'd2, v); chk("R12 no capture disabled", v, 1);

        // R7 stop when full
        wreg(3'd1, 17'h0);
        wreg(3'd0, 17'h09);
        for (int i = 0; i < 260; i++) begin
            bvld[0] = 1'b1; btt[0] = 5'h0; baddr[0] = 32'(i);
            @(negedge clk);
        end
        bvld[0] = 1'b0;
        rreg(3'd2, v); chk("R7 status full", v, 32'h600);
        rd_entry(255, hi, lo); chk("R7 last slot", lo, 255);
        rd_entry(0, hi, lo); chk("R7 first slot kept", lo, 0);

        // R10 re-arm
        wreg(3'd0, 17'h08); wreg(3'd0, 17'h09);
        rreg(3'd2, v); chk("R10 cleared", v, 0);

        // R8 wrap and stop on watchpoint pulse
        wreg(3'd0, 17'h00); wreg(3'd0, 17'h01);
        for (int i = 0; i < 300; i++) begin
            bvld[0] = 1'b1; baddr[0] = 32'(1000 + i); wp = (i == 299);
            @(negedge clk);
        end
        wp = 1'b0;
        for (int i = 0; i < 5; i++) begin
            baddr[0] = 32'(5000 + i);
            @(negedge clk);
        end
        bvld[0] = 1'b0;
        rreg(3'd2, v); chk("R8 status wrapped", v, 32'h32C);
        rd_entry(43, hi, lo); chk("R8 event slot", lo, 1299);
        rd_entry(44, hi, lo); chk("R8 first lap kept", lo, 1044);

        // R9 stop on condition match, watchpoint ignored
        wreg(3'd0, 17'h00);
        wreg(3'd1, 17'h27);
        wreg(3'd0, 17'h81);
        for (int i = 0; i < 20; i++) begin
            bvld[0] = 1'b1; btt[0] = (i == 10) ? 5'h7 : 5'h0;
            baddr[0] = 32'(i); wp = (i == 5);
            @(negedge clk);
        end
        bvld[0] = 1'b0; wp = 1'b0;
        rreg(3'd2, v); chk("R9 stop on match", v, 32'h20B);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule